// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block sits on the host side of an 8-bit NAND flash bus. It takes one request at a time over a valid/ready handshake and turns it into strobe-level bus cycles. A request can send a command byte, send a full page address, write a run of data bytes, or read a run of data bytes. For an address request the block takes a 12-bit column and a 17-bit row (page) address and packs them into five byte cycles. It drives the chip-enable, command-latch, address-latch, write-enable, read-enable and write-protect lines. It drives or samples the 8-bit I/O bus.

Each byte cycle has three phases: a setup phase, a strobe-low phase and a hold phase. Parameters set the length of each phase in system clock cycles. Some commands start an internal device operation: page-program confirm (0x10), block-erase confirm (0xD0) and read confirm (0x30). After one of these, the block waits on the ready/busy input before it accepts further work. A timeout bounds that wait. The write-protect line follows a host control bit. While that bit is clear, the block refuses the commands that start or confirm a program or an erase.

Top module: `nand_bus_sequencer`

## Requirements
- R1: While reset is active, CE#, WE# and RE# are high, CLE, ALE and the bus output enable are low, WP# is low, and `reqReady` is high.
- R2: A command request produces exactly one byte cycle in which CLE is high, ALE is low and CE# is low. The command byte is on the bus when WE# rises, and RE# stays high.
- R3: An address request with a column below 2112 produces five ALE-high, CLE-low byte cycles, in this order: column[7:0]; {4'b0, column[11:8]}; row[7:0]; row[15:8]; {7'b0, row[16]}.
- R4: An address request with a column above 2111 issues no bus cycle and sets `errCol`. A column of exactly 2111 is accepted. Error flags clear when the next request is accepted.
- R5: A write request of length N produces N byte cycles with CLE and ALE low. Each byte is taken from `wrData` on a cycle where `wrTake` is high, and the bytes go out in order.
- R6: A read request of length N produces N RE# low pulses while WE# stays high and the bus is not driven. Each byte is the bus value sampled at the clock edge that returns RE# high, and it is presented on `rdData` with a one-cycle `rdValid` pulse.
- R7: Each WE# or RE# low pulse lasts exactly T_PULSE clock cycles. Within one request, consecutive pulses are separated by exactly T_HOLD + T_SETUP high cycles.
- R8: WP# follows `wpAllow` one cycle later. While `wpAllow` is 0, the command codes 0x80, 0x10, 0x60 and 0xD0 are refused: `errWp` is set and no bus cycle occurs. Other command codes are still issued.
- R9: After command 0x10, 0xD0 or 0x30, `reqReady` stays low while the ready/busy input is low. It returns high within a few cycles of that input rising.
- R10: If the ready/busy input stays low for TIMEOUT cycles after such a command, `errTimeout` is set and `reqReady` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer idle, request taken when valid is also high |
| reqOp | input | 2 | 0 command, 1 address, 2 write, 3 read |
| reqCmd | input | 8 | Command byte |
| reqCol | input | 12 | Column address |
| reqRow | input | 17 | Row (page) address |
| reqLen | input | LEN_W | Byte count for write and read requests |
| wrData | input | 8 | Next write byte |
| wrTake | output | 1 | Write byte taken at this clock edge |
| rdData | output | 8 | Last byte read |
| rdValid | output | 1 | One-cycle pulse with each read byte |
| wpAllow | input | 1 | Program/erase permitted (drives WP#) |
| errCol | output | 1 | Column out of range on last request |
| errWp | output | 1 | Protected command refused on last request |
| errTimeout | output | 1 | Ready/busy wait timed out |
| nandCeN | output | 1 | Chip enable, active low |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write enable, active low |
| nandReN | output | 1 | Read enable, active low |
| nandWpN | output | 1 | Write protect, active low |
| nandIoOut | output | 8 | Bus value driven |
| nandIoOe | output | 1 | Bus drive enable |
| nandIoIn | input | 8 | Bus value sampled |
| nandRdy | input | 1 | Device ready/busy, high when ready |

## Verification
The bench builds the block with T_SETUP=1, T_PULSE=2 and T_HOLD=1, so the exact pulse widths and the inter-byte gap are checked at the shortest legal setting and with asymmetric phases. BUSY_GUARD=4 and TIMEOUT=40 keep the busy-wait window short. A device model that holds ready/busy low makes the timeout path reachable in a few dozen cycles. LEN_W=8 allows multi-byte write and read runs. The column boundary cases 2111, 2112 and 4095 come from the vector table.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [1:0] {
    OP_CMD   = 2'd0,
    OP_ADDR  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } nand_op_e;

  typedef enum logic [1:0] {
    SRC_CMD   = 2'd0,
    SRC_ADDR  = 2'd1,
    SRC_WDATA = 2'd2
  } byte_src_e;

  // strobes from control to datapath, one set per clock
  typedef struct packed {
    logic      ceOn;
    logic      cleOn;
    logic      aleOn;
    logic      weLow;
    logic      reLow;
    logic      drive;
    logic      latchReq;
    logic      loadByte;
    byte_src_e src;
    logic [2:0] addrIdx;
    logic      capture;
  } bus_ctl_t;

  localparam int PAGE_BYTES  = 2112;
  localparam int ADDR_CYCLES = 5;

  localparam logic [7:0] CMD_PROG_SETUP  = 8'h80;
  localparam logic [7:0] CMD_PROG_GO     = 8'h10;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
  localparam logic [7:0] CMD_READ_GO     = 8'h30;

  function automatic logic isProtected(input logic [7:0] c);
    return (c == CMD_PROG_SETUP) || (c == CMD_PROG_GO) ||
           (c == CMD_ERASE_SETUP) || (c == CMD_ERASE_GO);
  endfunction

  function automatic logic startsBusy(input logic [7:0] c);
    return (c == CMD_PROG_GO) || (c == CMD_ERASE_GO) || (c == CMD_READ_GO);
  endfunction

endpackage

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int T_SETUP    = 2,
  parameter int T_PULSE    = 3,
  parameter int T_HOLD     = 2,
  parameter int BUSY_GUARD = 4,
  parameter int TIMEOUT    = 50000,
  parameter int LEN_W      = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  nand_op_e         reqOp,
  input  logic [7:0]       reqCmd,
  input  logic [11:0]      reqCol,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             wpAllow,
  input  logic             rdySync,
  output logic             reqReady,
  output logic             wrTake,
  output bus_ctl_t         ctl,
  output logic             errCol,
  output logic             errWp,
  output logic             errTimeout
);

  localparam int PH_MAX = (T_SETUP > T_PULSE) ? ((T_SETUP > T_HOLD) ? T_SETUP : T_HOLD)
                                              : ((T_PULSE > T_HOLD) ? T_PULSE : T_HOLD);
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int TO_W   = $clog2(TIMEOUT + 1);
  localparam logic [11:0] COL_MAX = 12'(PAGE_BYTES - 1);

  typedef enum logic [2:0] {ST_IDLE, ST_SETUP, ST_PULSE, ST_HOLD, ST_BUSY} state_e;

  state_e           state;
  logic [PH_W-1:0]  phCnt;
  logic [LEN_W-1:0] byteIdx;
  logic [LEN_W-1:0] lenReg;
  nand_op_e         opReg;
  logic             busyAfter;
  logic [TO_W-1:0]  toCnt;

  logic colBad, wpBad, emptyRun, lastByte;

  assign colBad   = (reqOp == OP_ADDR) && (reqCol > COL_MAX);
  assign wpBad    = (reqOp == OP_CMD) && !wpAllow && isProtected(reqCmd);
  assign emptyRun = ((reqOp == OP_WRITE) || (reqOp == OP_READ)) && (reqLen == '0);

  always_comb begin
    case (opReg)
      OP_CMD:  lastByte = 1'b1;
      OP_ADDR: lastByte = (byteIdx == LEN_W'(ADDR_CYCLES - 1));
      default: lastByte = (byteIdx == lenReg - LEN_W'(1));
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      phCnt      <= '0;
      byteIdx    <= '0;
      lenReg     <= '0;
      opReg      <= OP_CMD;
      busyAfter  <= 1'b0;
      toCnt      <= '0;
      errCol     <= 1'b0;
      errWp      <= 1'b0;
      errTimeout <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (reqValid) begin
          errCol     <= colBad;
          errWp      <= wpBad;
          errTimeout <= 1'b0;
          opReg      <= reqOp;
          lenReg     <= reqLen;
          busyAfter  <= (reqOp == OP_CMD) && startsBusy(reqCmd);
          phCnt      <= '0;
          byteIdx    <= '0;
          if (!(colBad || wpBad || emptyRun)) state <= ST_SETUP;
        end
        ST_SETUP: begin
          if (phCnt == PH_W'(T_SETUP - 1)) begin
            phCnt <= '0;
            state <= ST_PULSE;
          end else phCnt <= phCnt + 1'b1;
        end
        ST_PULSE: begin
          if (phCnt == PH_W'(T_PULSE - 1)) begin
            phCnt <= '0;
            state <= ST_HOLD;
          end else phCnt <= phCnt + 1'b1;
        end
        ST_HOLD: begin
          if (phCnt == PH_W'(T_HOLD - 1)) begin
            phCnt <= '0;
            if (!lastByte) begin
              byteIdx <= byteIdx + 1'b1;
              state   <= ST_SETUP;
            end else if (busyAfter) begin
              toCnt <= '0;
              state <= ST_BUSY;
            end else state <= ST_IDLE;
          end else phCnt <= phCnt + 1'b1;
        end
        ST_BUSY: begin
          toCnt <= toCnt + 1'b1;
          if ((toCnt >= TO_W'(BUSY_GUARD)) && rdySync) state <= ST_IDLE;
          else if (toCnt == TO_W'(TIMEOUT - 1)) begin
            errTimeout <= 1'b1;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic active;
  assign active   = (state == ST_SETUP) || (state == ST_PULSE) || (state == ST_HOLD);
  assign reqReady = (state == ST_IDLE);

  always_comb begin
    ctl          = '0;
    ctl.ceOn     = active;
    ctl.cleOn    = active && (opReg == OP_CMD);
    ctl.aleOn    = active && (opReg == OP_ADDR);
    ctl.weLow    = (state == ST_PULSE) && (opReg != OP_READ);
    ctl.reLow    = (state == ST_PULSE) && (opReg == OP_READ);
    ctl.drive    = active && (opReg != OP_READ);
    ctl.latchReq = (state == ST_IDLE) && reqValid;
    ctl.loadByte = (state == ST_SETUP) && (phCnt == '0) && (opReg != OP_READ);
    ctl.addrIdx  = byteIdx[2:0];
    ctl.capture  = (state == ST_HOLD) && (phCnt == '0) && (opReg == OP_READ);
    case (opReg)
      OP_CMD:  ctl.src = SRC_CMD;
      OP_ADDR: ctl.src = SRC_ADDR;
      default: ctl.src = SRC_WDATA;
    endcase
  end

  assign wrTake = ctl.loadByte && (opReg == OP_WRITE);

  // R4: a bad column is flagged and the sequencer never leaves idle
  p_col_reject_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && reqValid && reqOp == OP_ADDR && reqCol > COL_MAX)
      |=> (state == ST_IDLE && errCol));

  // R8: a refused protected command starts no cycle
  p_wp_refuse_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && reqValid && reqOp == OP_CMD && !wpAllow && isProtected(reqCmd))
      |=> (state == ST_IDLE && errWp));

  // R9: idle is only re-entered from busy once ready is seen, or on timeout
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY && !rdySync) |=> (state != ST_IDLE || errTimeout));

endmodule

// File: rtl/nand_seq_dp.sv
module nand_seq_dp
  import nand_seq_pkg::*;
#(
  parameter int T_PULSE = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  bus_ctl_t    ctl,
  input  logic [7:0]  reqCmd,
  input  logic [11:0] reqCol,
  input  logic [16:0] reqRow,
  input  logic [7:0]  wrData,
  input  logic        wpAllow,
  input  logic [7:0]  nandIoIn,
  input  logic        nandRdy,
  output logic        nandCeN,
  output logic        nandCle,
  output logic        nandAle,
  output logic        nandWeN,
  output logic        nandReN,
  output logic        nandWpN,
  output logic [7:0]  nandIoOut,
  output logic        nandIoOe,
  output logic [7:0]  rdData,
  output logic        rdValid,
  output logic        rdySync
);

  localparam int RUN_W = $clog2(T_PULSE + 2);

  logic [7:0]  cmdQ;
  logic [11:0] colQ;
  logic [16:0] rowQ;
  logic [7:0]  nextByte;
  logic [7:0]  addrByte;
  logic        rdyMeta;

  always_comb begin
    case (ctl.addrIdx)
      3'd0:    addrByte = colQ[7:0];
      3'd1:    addrByte = {4'b0000, colQ[11:8]};
      3'd2:    addrByte = rowQ[7:0];
      3'd3:    addrByte = rowQ[15:8];
      default: addrByte = {7'b0000000, rowQ[16]};
    endcase
    case (ctl.src)
      SRC_CMD:  nextByte = cmdQ;
      SRC_ADDR: nextByte = addrByte;
      default:  nextByte = wrData;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nandCeN   <= 1'b1;
      nandCle   <= 1'b0;
      nandAle   <= 1'b0;
      nandWeN   <= 1'b1;
      nandReN   <= 1'b1;
      nandWpN   <= 1'b0;
      nandIoOut <= '0;
      nandIoOe  <= 1'b0;
      rdData    <= '0;
      rdValid   <= 1'b0;
      cmdQ      <= '0;
      colQ      <= '0;
      rowQ      <= '0;
      rdyMeta   <= 1'b0;
      rdySync   <= 1'b0;
    end else begin
      nandCeN  <= !ctl.ceOn;
      nandCle  <= ctl.cleOn;
      nandAle  <= ctl.aleOn;
      nandWeN  <= !ctl.weLow;
      nandReN  <= !ctl.reLow;
      nandIoOe <= ctl.drive;
      nandWpN  <= wpAllow;
      if (ctl.latchReq) begin
        cmdQ <= reqCmd;
        colQ <= reqCol;
        rowQ <= reqRow;
      end
      if (ctl.loadByte) nandIoOut <= nextByte;
      rdValid <= ctl.capture;
      if (ctl.capture) rdData <= nandIoIn;
      rdyMeta <= nandRdy;
      rdySync <= rdyMeta;
    end
  end

  // pulse-width monitors for the checks below
  logic [RUN_W-1:0] weRun, reRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weRun <= '0;
      reRun <= '0;
    end else begin
      weRun <= nandWeN ? '0 : weRun + 1'b1;
      reRun <= nandReN ? '0 : reRun + 1'b1;
    end
  end

  p_we_width_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nandWeN) |-> (weRun == RUN_W'(T_PULSE)));

  p_re_width_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nandReN) |-> (reRun == RUN_W'(T_PULSE)));

  p_latch_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle));

  p_strobe_ce_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!nandWeN || !nandReN) |-> !nandCeN);

  p_read_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !nandReN |-> (nandWeN && !nandIoOe));

  p_byte_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    !nandWeN |-> $stable(nandIoOut));

endmodule

// File: rtl/nand_bus_sequencer.sv
module nand_bus_sequencer
  import nand_seq_pkg::*;
#(
  parameter int T_SETUP    = 2,
  parameter int T_PULSE    = 3,
  parameter int T_HOLD     = 2,
  parameter int BUSY_GUARD = 4,
  parameter int TIMEOUT    = 50000,
  parameter int LEN_W      = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [1:0]       reqOp,
  input  logic [7:0]       reqCmd,
  input  logic [11:0]      reqCol,
  input  logic [16:0]      reqRow,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [7:0]       wrData,
  output logic             wrTake,
  output logic [7:0]       rdData,
  output logic             rdValid,
  input  logic             wpAllow,
  output logic             errCol,
  output logic             errWp,
  output logic             errTimeout,
  output logic             nandCeN,
  output logic             nandCle,
  output logic             nandAle,
  output logic             nandWeN,
  output logic             nandReN,
  output logic             nandWpN,
  output logic [7:0]       nandIoOut,
  output logic             nandIoOe,
  input  logic [7:0]       nandIoIn,
  input  logic             nandRdy
);

  bus_ctl_t ctl;
  logic     rdySync;

  nand_seq_ctrl #(
    .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD),
    .BUSY_GUARD(BUSY_GUARD), .TIMEOUT(TIMEOUT), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(nand_op_e'(reqOp)),
    .reqCmd(reqCmd), .reqCol(reqCol), .reqLen(reqLen), .wpAllow(wpAllow),
    .rdySync(rdySync), .reqReady(reqReady), .wrTake(wrTake), .ctl(ctl),
    .errCol(errCol), .errWp(errWp), .errTimeout(errTimeout)
  );

  nand_seq_dp #(.T_PULSE(T_PULSE)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqCmd(reqCmd), .reqCol(reqCol),
    .reqRow(reqRow), .wrData(wrData), .wpAllow(wpAllow), .nandIoIn(nandIoIn),
    .nandRdy(nandRdy), .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle),
    .nandWeN(nandWeN), .nandReN(nandReN), .nandWpN(nandWpN), .nandIoOut(nandIoOut),
    .nandIoOe(nandIoOe), .rdData(rdData), .rdValid(rdValid), .rdySync(rdySync)
  );

endmodule

// File: tb/tb_nand_bus_sequencer.sv
module tb_nand_bus_sequencer;

  localparam int TS = 1, TP = 2, TH = 1, GUARD = 4, TMO = 40, LW = 8;
  localparam int BUSY_LEN = 20;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqReady, wrTake, rdValid, wpAllow = 1'b1;
  logic [1:0] reqOp = '0;
  logic [7:0] reqCmd = '0, wrData, rdData, nandIoOut, nandIoIn;
  logic [11:0] reqCol = '0;
  logic [16:0] reqRow = '0;
  logic [LW-1:0] reqLen = '0;
  logic errCol, errWp, errTimeout;
  logic nandCeN, nandCle, nandAle, nandWeN, nandReN, nandWpN, nandIoOe;
  logic nandRdy = 1'b1;

  always #4 clk = ~clk;

  nand_bus_sequencer #(.T_SETUP(TS), .T_PULSE(TP), .T_HOLD(TH),
    .BUSY_GUARD(GUARD), .TIMEOUT(TMO), .LEN_W(LW)) dut (.*);

  // device-side data and bookkeeping
  logic [7:0] wrMem [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
  logic [7:0] rdMem [4] = '{8'hA5, 8'h3C, 8'h00, 8'hFF};
  int wrIdx = 0, rdIdx = 0;
  assign wrData   = wrMem[wrIdx[1:0]];
  assign nandIoIn = rdMem[rdIdx[1:0]];

  logic [7:0] logByte [16];
  logic       logCle [16], logAle [16];
  logic [7:0] rdLog [8];
  int logN = 0, rdN = 0, wrTakes = 0, weFalls = 0, reFalls = 0, widthBad = 0;
  int weRun = 0, reRun = 0, highRun = 0, busyLeft = 0, violations = 0;
  int cyc = 0, rdyRiseCyc = 0, doneCyc = 0;
  bit prevWe = 1, prevRe = 1, gapArmed = 0, wrPend = 0, stuck = 0, busyWatch = 0;
  int nChecks = 0, nFail = 0;
  bit finished = 0;

  always @(negedge clk) begin
    bit weRise, weFall, reRise, reFall;
    cyc++;
    if (wrPend) wrIdx++;
    wrPend = wrTake;
    if (wrTake) wrTakes++;
    weRise = nandWeN && !prevWe;  weFall = !nandWeN && prevWe;
    reRise = nandReN && !prevRe;  reFall = !nandReN && prevRe;
    if (!nandWeN) weRun++;
    if (!nandReN) reRun++;
    if (weFall) weFalls++;
    if (reFall) reFalls++;
    if ((weFall || reFall) && gapArmed && highRun != TS + TH) widthBad++;
    if (weRise) begin
      if (weRun != TP) widthBad++;
      weRun = 0;
      if (logN < 16) begin
        logByte[logN] = nandIoOut; logCle[logN] = nandCle; logAle[logN] = nandAle;
      end
      logN++;
      if (nandCle && (nandIoOut == 8'h10 || nandIoOut == 8'hD0 || nandIoOut == 8'h30)) begin
        nandRdy = 1'b0;
        busyLeft = stuck ? 0 : BUSY_LEN;
      end
    end else if (busyLeft > 0) begin
      busyLeft--;
      if (busyLeft == 0) begin nandRdy = 1'b1; rdyRiseCyc = cyc; end
    end
    if (reRise) begin
      if (reRun != TP) widthBad++;
      reRun = 0;
      rdIdx++;
    end
    if (weRise || reRise) begin gapArmed = 1; highRun = 1; end
    else if (nandWeN && nandReN) highRun++;
    if (nandCeN) gapArmed = 0;
    if (rdValid && rdN < 8) begin rdLog[rdN] = rdData; rdN++; end
    if (busyWatch && !nandRdy && reqReady) violations++;
    prevWe = nandWeN; prevRe = nandReN;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doReq(input logic [1:0] op, input logic [7:0] c,
                       input logic [11:0] col, input logic [16:0] row, input int len);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    logN = 0; rdN = 0; wrTakes = 0; weFalls = 0; reFalls = 0; widthBad = 0;
    reqOp = op; reqCmd = c; reqCol = col; reqRow = row; reqLen = LW'(len);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (!reqReady) @(negedge clk);
    doneCyc = cyc;
    repeat (3) @(negedge clk);
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  cmd;
    logic [11:0] col;
    logic [16:0] row;
    logic        wp;
    logic        eCol;
    logic        eWp;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{2'd0, 8'hFF, 12'h000, 17'h00000, 1'b1, 1'b0, 1'b0},
    '{2'd1, 8'h00, 12'h000, 17'h00000, 1'b1, 1'b0, 1'b0},
    '{2'd1, 8'h00, 12'h83F, 17'h1FFFF, 1'b1, 1'b0, 1'b0},
    '{2'd1, 8'h00, 12'h840, 17'h00001, 1'b1, 1'b1, 1'b0},
    '{2'd1, 8'h00, 12'h5A3, 17'h12345, 1'b1, 1'b0, 1'b0},
    '{2'd0, 8'h80, 12'h000, 17'h00000, 1'b0, 1'b0, 1'b1},
    '{2'd0, 8'h70, 12'h000, 17'h00000, 1'b0, 1'b0, 1'b0},
    '{2'd0, 8'h60, 12'h000, 17'h00000, 1'b1, 1'b0, 1'b0},
    '{2'd1, 8'h00, 12'hFFF, 17'h0ABCD, 1'b1, 1'b1, 1'b0}
  };

  task automatic finishRun;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    logic [7:0] expB [5];
    int expN, bad;
    bit expCle;
    // R1: reset state
    repeat (2) @(negedge clk);
    chk(nandCeN && nandWeN && nandReN && !nandCle && !nandAle && !nandIoOe &&
        !nandWpN && reqReady, "R1", "reset pins",
        {nandCeN, nandWeN, nandReN, nandCle, nandAle, nandIoOe, nandWpN, reqReady},
        8'b11100001);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 9; i++) begin
      vec_t v;
      v = VECS[i];
      wpAllow = v.wp;
      doReq(v.op, v.cmd, v.col, v.row, 0);
      if (v.eCol || v.eWp) expN = 0;
      else if (v.op == 2'd0) begin expN = 1; expB[0] = v.cmd; end
      else begin
        expN = 5;
        expB[0] = v.col[7:0]; expB[1] = {4'h0, v.col[11:8]};
        expB[2] = v.row[7:0]; expB[3] = v.row[15:8]; expB[4] = {7'h0, v.row[16]};
      end
      expCle = (v.op == 2'd0);
      bad = 0;
      for (int k = 0; k < expN && k < logN; k++)
        if (logByte[k] != expB[k] || logCle[k] != expCle || logAle[k] == expCle) bad++;
      chk(logN == expN && bad == 0, v.op == 2'd0 ? "R2" : "R3",
          $sformatf("vector %0d byte count/mismatches", i), logN * 256 + bad, expN * 256);
      chk(errCol == v.eCol, "R4", $sformatf("vector %0d errCol", i), errCol, v.eCol);
      chk(errWp == v.eWp, "R8", $sformatf("vector %0d errWp", i), errWp, v.eWp);
      chk(nandWpN == v.wp, "R8", $sformatf("vector %0d WP# pin", i), nandWpN, v.wp);
    end

    // R5: write run of three bytes
    wpAllow = 1'b1;
    wrIdx = 0; wrPend = 0;
    doReq(2'd2, 8'h00, 12'h0, 17'h0, 3);
    bad = 0;
    for (int k = 0; k < 3 && k < logN; k++)
      if (logByte[k] != wrMem[k] || logCle[k] || logAle[k]) bad++;
    chk(logN == 3 && bad == 0, "R5", "write bytes", logN * 256 + bad, 3 * 256);
    chk(wrTakes == 3, "R5", "wrTake pulses", wrTakes, 3);
    chk(widthBad == 0 && reFalls == 0, "R7", "write strobe widths", widthBad, 0);

    // R6: read run of four bytes
    rdIdx = 0;
    doReq(2'd3, 8'h00, 12'h0, 17'h0, 4);
    bad = 0;
    for (int k = 0; k < 4 && k < rdN; k++) if (rdLog[k] != rdMem[k]) bad++;
    chk(rdN == 4 && bad == 0, "R6", "read bytes", rdN * 256 + bad, 4 * 256);
    chk(reFalls == 4 && weFalls == 0, "R6", "read strobes", reFalls * 16 + weFalls, 4 * 16);
    chk(widthBad == 0, "R7", "read strobe widths", widthBad, 0);

    // R9: busy wait after read confirm
    busyWatch = 1; violations = 0;
    doReq(2'd0, 8'h30, 12'h0, 17'h0, 0);
    busyWatch = 0;
    chk(violations == 0, "R9", "ready while busy", violations, 0);
    chk(doneCyc - rdyRiseCyc >= 0 && doneCyc - rdyRiseCyc <= 5, "R9",
        "release delay", doneCyc - rdyRiseCyc, 3);
    chk(!errTimeout, "R9", "no timeout", errTimeout, 0);

    // R10: device never becomes ready
    stuck = 1;
    doReq(2'd0, 8'hD0, 12'h0, 17'h0, 0);
    chk(errTimeout == 1'b1, "R10", "timeout flag", errTimeout, 1);
    chk(nandRdy == 1'b0, "R10", "device still busy", nandRdy, 0);
    stuck = 0; nandRdy = 1'b1;
    repeat (4) @(negedge clk);
    doReq(2'd0, 8'hFF, 12'h0, 17'h0, 0);
    chk(errTimeout == 1'b0 && logN == 1, "R10", "flag cleared by next request",
        errTimeout, 0);

    // R4: flag clears on the next good request
    doReq(2'd1, 8'h00, 12'h840, 17'h0, 0);
    doReq(2'd1, 8'h00, 12'h001, 17'h0, 0);
    chk(errCol == 1'b0 && logN == 5, "R4", "errCol cleared", errCol, 0);

    finishRun();
  end

endmodule